// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller sits in the always-on part of a small microcontroller and moves it between a running state and three low-power states. When the core raises its sleep request, a two-bit mode selection picks the state to enter. In the light sleep state only the core clock stops, and a per-peripheral mask chooses which peripheral clocks keep running. The power-down state stops every digital clock and leaves on only the oscillators named in an analog keep mask. The deep power-down state cuts the main domain supply and holds its reset.

Four clock sources are modelled as enable outputs paired with ready inputs: a low-power oscillator, an internal RC oscillator, a crystal oscillator, and a PLL that runs from the crystal. The selected source is captured in an always-on register while the core runs. On every wake-up the core clock is released only when each source that the selection needs reports ready, so the wake latency depends on which source is selected and on which sources were kept running. An enabled interrupt wakes the block from sleep or power-down. Deep power-down ends only on the dedicated wake pin or a reset. A wake-pin exit powers the main domain back up, keeps its reset asserted until the clock is ready, and sets a sticky always-on flag so software can tell what caused the restart.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, the main domain is powered with `main_rst_n` low and `core_clk_en` low, `aon_dpd_flag` is 0, the retained source is 0, and `core_clk_en` rises once the low-power oscillator reports ready.
- R2: In the running state, `osc_en` equals the need mask of the captured source: source 0 needs bit 0 (low-power oscillator), source 1 needs bit 1 (RC oscillator), source 2 needs bit 2 (crystal), source 3 needs bits 2 and 3 (crystal and PLL).
- R3: A sleep request with `mode_sel` = 0 enters sleep: `core_clk_en` is 0, `periph_clk_en` equals `periph_keep`, and `osc_en` keeps the need mask.
- R4: A sleep request with `mode_sel` = 1 enters power-down: `core_clk_en` and all `periph_clk_en` bits are 0, and `osc_en` equals the need mask ANDed with `ana_keep`.
- R5: A sleep request with `mode_sel` = 2 or 3 enters deep power-down: `main_pwr_on`, `main_rst_n`, `core_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R6: An interrupt line that is high together with its `irq_en` bit wakes the block from sleep or power-down. Interrupt lines whose enable bit is 0 have no effect.
- R7: After a wake event the core clock stays off until every source in the need mask reports ready. The latency therefore grows with the start-up time of the sources that were switched off.
- R8: In deep power-down, interrupts are ignored. `wake_pin` restores `main_pwr_on` at once and holds `main_rst_n` low until the needed sources are ready.
- R9: `aon_wake_src` captures `wake_src` while the core runs. Changes on `wake_src` in any low-power state are ignored, and the wake-up uses the captured value.
- R10: `aon_dpd_flag` is set by a wake-pin exit from deep power-down and stays set through later runs and sleeps until `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request from the core |
| mode_sel | input | 2 | 0 sleep, 1 power-down, 2 or 3 deep power-down |
| wake_src | input | 2 | Clock source selection for run and wake |
| ana_keep | input | 4 | Oscillators kept on in power-down (bit order as in osc_en) |
| periph_keep | input | N_PERIPH | Peripheral clocks kept on in sleep |
| irq | input | N_IRQ | Interrupt lines |
| irq_en | input | N_IRQ | Interrupt wake enables |
| wake_pin | input | 1 | Dedicated deep power-down wake pin |
| osc_rdy | input | 4 | Stable indications of the clock sources |
| core_clk_en | output | 1 | Core clock gate |
| periph_clk_en | output | N_PERIPH | Peripheral clock gates |
| osc_en | output | 4 | Enables: bit 0 low-power osc, 1 RC osc, 2 crystal, 3 PLL |
| main_pwr_on | output | 1 | Main domain power switch |
| main_rst_n | output | 1 | Main domain reset, active low |
| aon_dpd_flag | output | 1 | Retained deep power-down wake flag |
| aon_wake_src | output | 2 | Retained clock source selection |

## Verification
Two collisions are forced on purpose. In the first, an enabled interrupt is raised in the same cycle as a sleep request. The bench expects the block to enter sleep, drop the core clock for exactly two edges, and resume on the third. In the second, the wake pin and enabled interrupts arrive together during deep power-down. The bench expects the restart to follow the pin: reset stays held until the clock source is ready, and the flag becomes set. Wake latencies under random mode, source and keep-mask choices are compared with a bench function built from the modelled oscillator start-up delays.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int N_IRQ    = 8,
  parameter int N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic [1:0]          mode_sel,
  input  logic [1:0]          wake_src,
  input  logic [3:0]          ana_keep,
  input  logic [N_PERIPH-1:0] periph_keep,
  input  logic [N_IRQ-1:0]    irq,
  input  logic [N_IRQ-1:0]    irq_en,
  input  logic                wake_pin,
  input  logic [3:0]          osc_rdy,
  output logic                core_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic [3:0]          osc_en,
  output logic                main_pwr_on,
  output logic                main_rst_n,
  output logic                aon_dpd_flag,
  output logic [1:0]          aon_wake_src
);

  typedef enum logic [2:0] {S_RUN, S_SLEEP, S_PDOWN, S_WAKE, S_DPD, S_BOOT} st_t;

  st_t        state, nxt;
  logic [1:0] src_q;
  logic [3:0] need;
  logic       all_rdy, irq_hit;

  always_comb begin
    case (src_q)
      2'd0:    need = 4'b0001;
      2'd1:    need = 4'b0010;
      2'd2:    need = 4'b0100;
      default: need = 4'b1100;
    endcase
  end

  assign all_rdy = ((osc_rdy & need) == need);
  assign irq_hit = |(irq & irq_en);

  always_comb begin
    nxt = state;
    case (state)
      S_RUN:
        if (!all_rdy)       nxt = S_WAKE;
        else if (sleep_req) nxt = (mode_sel == 2'd0) ? S_SLEEP :
                                  (mode_sel == 2'd1) ? S_PDOWN : S_DPD;
      S_SLEEP, S_PDOWN:
        if (irq_hit)  nxt = S_WAKE;
      S_WAKE:
        if (all_rdy)  nxt = S_RUN;
      S_DPD:
        if (wake_pin) nxt = S_BOOT;
      S_BOOT:
        if (all_rdy)  nxt = S_RUN;
      default:        nxt = S_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_BOOT;
      src_q        <= 2'd0;
      aon_dpd_flag <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_RUN) src_q <= wake_src;
      if (state == S_DPD && wake_pin) aon_dpd_flag <= 1'b1;
    end
  end

  assign core_clk_en   = (state == S_RUN) && all_rdy;
  assign periph_clk_en = (state == S_RUN)   ? {N_PERIPH{all_rdy}} :
                         (state == S_SLEEP) ? periph_keep : '0;
  assign osc_en        = (state == S_DPD)   ? 4'b0000 :
                         (state == S_PDOWN) ? (need & ana_keep) : need;
  assign main_pwr_on   = (state != S_DPD);
  assign main_rst_n    = (state != S_DPD) && (state != S_BOOT);
  assign aon_wake_src  = src_q;

  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAKE && !all_rdy) |=> (state != S_RUN));
  a_r8_pin_only_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DPD && !wake_pin) |=> (state == S_DPD));
  a_r6_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_SLEEP || state == S_PDOWN) && irq_hit) |=> (state == S_WAKE));
  a_r9_src_retained: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN) |=> $stable(aon_wake_src));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aon_dpd_flag |=> aon_dpd_flag);
  a_r5_off_means_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr_on |-> (!main_rst_n && !core_clk_en && osc_en == 4'b0000));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int NI = 8, NP = 4;
  localparam int D0 = 2, D1 = 5, D2 = 12, D3 = 7;

  logic clk = 0, rst_n = 0, sleep_req = 0, wake_pin = 0;
  logic [1:0] mode_sel = 0, wake_src = 0;
  logic [3:0] ana_keep = 0, osc_rdy = 0;
  logic [NP-1:0] periph_keep = 0;
  logic [NI-1:0] irq = 0, irq_en = 0;
  logic core_clk_en, main_pwr_on, main_rst_n, aon_dpd_flag;
  logic [NP-1:0] periph_clk_en;
  logic [3:0] osc_en;
  logic [1:0] aon_wake_src;
  int vectors = 0, errs = 0;
  int cnt [4];

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(NI), .N_PERIPH(NP)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_sel(mode_sel),
    .wake_src(wake_src), .ana_keep(ana_keep), .periph_keep(periph_keep),
    .irq(irq), .irq_en(irq_en), .wake_pin(wake_pin), .osc_rdy(osc_rdy),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .main_pwr_on(main_pwr_on), .main_rst_n(main_rst_n),
    .aon_dpd_flag(aon_dpd_flag), .aon_wake_src(aon_wake_src));

  // oscillator start-up model: ready after D cycles of enable; PLL counts once the crystal is ready
  initial for (int i = 0; i < 4; i++) cnt[i] = 0;
  always @(negedge clk) begin
    logic [3:0] old;
    old = osc_rdy;
    for (int i = 0; i < 4; i++) begin
      int d;
      d = (i == 0) ? D0 : (i == 1) ? D1 : (i == 2) ? D2 : D3;
      if (!(osc_en[i] && (i != 3 || old[2]))) begin cnt[i] = 0; osc_rdy[i] = 1'b0; end
      else if (cnt[i] == d) osc_rdy[i] = 1'b1;
      else cnt[i] = cnt[i] + 1;
    end
  end

  function automatic logic [3:0] need_of(input logic [1:0] s);
    case (s)
      2'd0: return 4'b0001;
      2'd1: return 4'b0010;
      2'd2: return 4'b0100;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic int lat_of(input logic [1:0] s, input logic [3:0] kept);
    int t, t2;
    case (s)
      2'd0: t = kept[0] ? 0 : D0 + 1;
      2'd1: t = kept[1] ? 0 : D1 + 1;
      2'd2: t = kept[2] ? 0 : D2 + 1;
      default: begin
        t2 = kept[2] ? 0 : D2 + 1;
        t  = (kept[2] && kept[3]) ? 0 : t2 + D3 + 1;
      end
    endcase
    return ((t == 0) ? 1 : t) + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  task automatic wait_run();
    int k = 0;
    while (!core_clk_en && k < 300) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    bit saw_dpd;
    logic [1:0] src, md;
    logic [3:0] ak, kept;
    logic [NP-1:0] pk;
    logic [NI-1:0] ie;
    saw_dpd = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(main_pwr_on && !main_rst_n && !core_clk_en && !aon_dpd_flag && aon_wake_src == 0,
        "R1 reset state", {main_pwr_on, main_rst_n, core_clk_en, aon_dpd_flag}, 4'b1000);
    chk(osc_en == 4'b0001, "R1 reset osc", osc_en, 1);
    rst_n = 1;
    wait_run();
    chk(core_clk_en && main_rst_n, "R1 boot release", {core_clk_en, main_rst_n}, 3);

    // collision: sleep request and enabled interrupt in the same cycle (R3, R6)
    irq_en = 8'h10; mode_sel = 0;
    @(negedge clk); sleep_req = 1; irq = 8'h10;
    @(posedge clk); #1; sleep_req = 0;
    chk(!core_clk_en, "R3 sleep entered despite irq", core_clk_en, 0);
    @(posedge clk); #1;
    chk(!core_clk_en, "R6 wake cycle", core_clk_en, 0);
    @(posedge clk); #1;
    chk(core_clk_en, "R6 resumed", core_clk_en, 1);
    irq = 0;

    for (int it = 0; it < 40; it++) begin
      src = 2'($urandom % 4);
      md  = (it == 0) ? 2'd2 : 2'($urandom % 4);
      ak  = 4'($urandom);
      pk  = NP'($urandom);
      ie  = NI'($urandom);
      if (ie == 0 || ie == '1) ie = 8'h21;
      @(negedge clk);
      wake_src = src; ana_keep = ak; periph_keep = pk; irq_en = ie; mode_sel = md;
      repeat (2) @(negedge clk);
      wait_run();
      repeat (2) @(negedge clk);
      chk(osc_en == need_of(src), "R2 run osc mask", osc_en, need_of(src));
      chk(aon_wake_src == src, "R9 captured in run", aon_wake_src, src);
      sleep_req = 1;
      @(negedge clk); sleep_req = 0;
      if (md == 0) begin
        chk(!core_clk_en && periph_clk_en == pk, "R3 sleep gates", periph_clk_en, pk);
        chk(osc_en == need_of(src), "R3 sleep osc", osc_en, need_of(src));
        kept = 4'hF;
      end else if (md == 1) begin
        chk(!core_clk_en && periph_clk_en == 0, "R4 pdown gates", periph_clk_en, 0);
        chk(osc_en == (need_of(src) & ak), "R4 pdown osc", osc_en, need_of(src) & ak);
        kept = ak;
      end else begin
        chk(!main_pwr_on && !main_rst_n && !core_clk_en && periph_clk_en == 0 && osc_en == 0,
            "R5 deep off", {main_pwr_on, main_rst_n, osc_en}, 0);
        kept = 4'h0;
        saw_dpd = 1;
      end
      repeat (3) @(negedge clk);
      wake_src = ~src;
      irq = (md >= 2) ? ie : ~ie;
      repeat (4) @(negedge clk);
      chk(!core_clk_en, (md >= 2) ? "R8 irq ignored in deep" : "R6 disabled irq ignored", core_clk_en, 0);
      chk(aon_wake_src == src, "R9 src retained", aon_wake_src, src);
      wake_src = src;
      if (md >= 2) begin
        wake_pin = 1;
        irq = ie;
      end else irq = ie & (~ie + 1'b1);
      n = 0;
      while (n < 200) begin
        @(posedge clk); #1; n++;
        if (n == 1 && md >= 2) begin
          wake_pin = 0;
          chk(main_pwr_on && !main_rst_n, "R8 power up, reset held", {main_pwr_on, main_rst_n}, 2);
        end
        if (core_clk_en) break;
      end
      irq = 0;
      chk(n == lat_of(src, kept), "R7 wake latency", n, lat_of(src, kept));
      if (md >= 2) chk(main_rst_n && aon_dpd_flag, "R8 restart flag", {main_rst_n, aon_dpd_flag}, 3);
      else if (saw_dpd) chk(aon_dpd_flag, "R10 flag sticky", aon_dpd_flag, 1);
    end

    // R10 cleared only by reset
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(!aon_dpd_flag && aon_wake_src == 0, "R10 reset clears flag", aon_dpd_flag, 0);
    rst_n = 1;
    wait_run();
    chk(core_clk_en && !aon_dpd_flag, "R1 reboot", {core_clk_en, aon_dpd_flag}, 2);
    summary();
  end
endmodule